// File: doc/BRIEF.md
# Receive DMA Control and Status Register

This block is the control and status register for the receive side of a packet link controller. It sits between a host register bus and the receive engine that moves packet payload into a receive FIFO. The host reads one 8-bit status word that shows whether the FIFO holds data and whether a packet is in reception. It writes the same word to request a FIFO flush or to turn on a forced-busy mode.

The block keeps its own occupancy count of the receive FIFO from push and pop strobes. It drives a one-cycle flush strobe to the storage. For every packet it latches an accept-or-busy decision at start of packet and presents it to the link as the acknowledge select. With forced busy on, a packet that is already arriving still runs to its end and can raise the DMA-complete interrupt. Every packet that starts later is answered busy. The interrupt is a sticky flag that the host acknowledges on a separate input.

Top module: `rxdma_ctl`

## Requirements
- R1: After reset the status word reads 0x00, `fifo_clr` is 0, `ack_busy` is 0 and `dma_done_irq` is 0.
- R2: Status bits 7..4 always read 0, whatever value is written to them.
- R3: Status bit 3 reads 1 when the tracked FIFO count is non-zero and 0 when it is zero. Each push raises the count by one and each pop lowers it by one. A write to bit 3 has no effect on it.
- R4: A host write with bit 2 set produces exactly one cycle of `fifo_clr`, in the cycle after the write. Bit 2 always reads 0.
- R5: In the `fifo_clr` cycle the count returns to zero, and a push in that same cycle is discarded.
- R6: Status bit 1 reads 1 from the cycle after an accepted start of packet until the cycle after its end of packet. A write to bit 1 has no effect on it.
- R7: Status bit 0 (force busy) is read/write. A start of packet seen while it is 1 sets `ack_busy` to 1 and leaves bit 1 at 0.
- R8: `ack_busy` is latched at each start of packet and holds until the next one. Changing force busy in the middle of a packet does not change it.
- R9: Setting force busy while a packet is in reception lets that packet finish. On a good CRC its end raises `dma_done_irq`.
- R10: `dma_done_irq` is set by an end of packet that has `eop_crc_ok` and belongs to an accepted packet. It stays set until `irq_ack`, and a set in the same cycle as `irq_ack` wins. A CRC error or a refused packet does not set it.
- R11: The count never exceeds FIFO_DEPTH and never goes below zero. A push when full and a pop when empty are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_wr_en | input | 1 | Host write strobe for the status word |
| reg_wr_data | input | 8 | Host write data |
| reg_rd_data | output | 8 | Current status word |
| fifo_push | input | 1 | One entry written into the receive FIFO |
| fifo_pop | input | 1 | One entry read out of the receive FIFO |
| fifo_clr | output | 1 | One-cycle flush strobe to the FIFO storage |
| rx_sop | input | 1 | Start-of-packet pulse from the link |
| rx_eop | input | 1 | End-of-packet pulse from the link |
| eop_crc_ok | input | 1 | Good-CRC qualifier, valid with `rx_eop` |
| ack_busy | output | 1 | Acknowledge select: 1 answers busy, 0 accepts |
| irq_ack | input | 1 | Clears the DMA-complete interrupt |
| dma_done_irq | output | 1 | Sticky DMA-complete interrupt |

## Verification
The assertions assume that the link frames packets properly. No new start of packet arrives while an accepted packet is still in reception, and start and end of packet never share a cycle. The directed scenarios always close each packet with an end pulse before opening the next one. They never pulse both strobes together. They raise `eop_crc_ok` only alongside `rx_eop`. Push and pop requests are driven in separate cycles, except where the flush-priority case overlaps a push on purpose.

// File: rtl/rxdma_pkg.sv
package rxdma_pkg;

    localparam int STAT_W     = 8;
    localparam int BIT_NEMPTY = 3;
    localparam int BIT_FLUSH  = 2;
    localparam int BIT_RXMON  = 1;
    localparam int BIT_FBUSY  = 0;

    typedef struct packed {
        logic fbusy;
        logic flush;
    } ctl_state_t;

    typedef struct packed {
        logic active;
        logic busy_sel;
        logic irq;
    } pkt_state_t;

endpackage

// File: rtl/rxdma_ctl_reg.sv
module rxdma_ctl_reg (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_en,
    input  logic wr_fbusy,
    input  logic wr_flush,
    output logic fbusy,
    output logic flush
);
    import rxdma_pkg::*;

    ctl_state_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.flush = 1'b0;
        if (wr_en) begin
            st_d.fbusy = wr_fbusy;
            st_d.flush = wr_flush;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign fbusy = st_q.fbusy;
    assign flush = st_q.flush;

    AST_FLUSH_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !flush); // R4
    AST_FLUSH_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_flush) |=> flush); // R4

endmodule

// File: rtl/rxdma_fifo_level.sv
module rxdma_fifo_level #(
    parameter int FIFO_DEPTH = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic push,
    input  logic pop,
    input  logic flush,
    output logic nonempty
);
    localparam int CNT_W = $clog2(FIFO_DEPTH + 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(FIFO_DEPTH);

    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic do_push, do_pop;

    always_comb begin
        do_push = push && (cnt_q != FULL_CNT);
        do_pop  = pop  && (cnt_q != '0);
        cnt_d   = cnt_q;
        if (flush)                  cnt_d = '0;
        else if (do_push && !do_pop) cnt_d = cnt_q + 1'b1;
        else if (do_pop && !do_push) cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign nonempty = (cnt_q != '0);

    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !nonempty); // R5
    AST_PUSH_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop && !flush) |=> nonempty); // R3
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= FULL_CNT); // R11
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (!nonempty && !push) |=> !nonempty); // R11

endmodule

// File: rtl/rxdma_pkt_ctl.sv
module rxdma_pkt_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic fbusy,
    input  logic sop,
    input  logic eop,
    input  logic crc_ok,
    input  logic irq_ack,
    output logic active,
    output logic busy_sel,
    output logic irq
);
    import rxdma_pkg::*;

    pkt_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (sop) begin
            st_d.busy_sel = fbusy;
            st_d.active   = !fbusy;
        end else if (eop) begin
            st_d.active = 1'b0;
        end
        if (irq_ack) st_d.irq = 1'b0;
        if (eop && st_q.active && crc_ok) st_d.irq = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign active   = st_q.active;
    assign busy_sel = st_q.busy_sel;
    assign irq      = st_q.irq;

    AST_NO_NESTED_SOP: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> !sop); // R6
    AST_DECISION_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !sop |=> $stable(busy_sel)); // R8
    AST_REFUSED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (sop && fbusy) |=> (!active && busy_sel)); // R7
    AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !irq_ack) |=> irq); // R10
    AST_IRQ_ONLY_GOOD: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq && !(eop && active && crc_ok)) |=> !irq); // R10
    AST_FINISH_UNDER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (active && fbusy && eop && crc_ok) |=> irq); // R9

endmodule

// File: rtl/rxdma_ctl.sv
module rxdma_ctl #(
    parameter int FIFO_DEPTH = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       reg_wr_en,
    input  logic [7:0] reg_wr_data,
    output logic [7:0] reg_rd_data,
    input  logic       fifo_push,
    input  logic       fifo_pop,
    output logic       fifo_clr,
    input  logic       rx_sop,
    input  logic       rx_eop,
    input  logic       eop_crc_ok,
    output logic       ack_busy,
    input  logic       irq_ack,
    output logic       dma_done_irq
);
    import rxdma_pkg::*;

    logic fbusy, flush, nonempty, active;
    logic unused_wr_bits;

    assign unused_wr_bits = ^{reg_wr_data[7:4], reg_wr_data[BIT_NEMPTY], reg_wr_data[BIT_RXMON]};

    rxdma_ctl_reg u_reg (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (reg_wr_en),
        .wr_fbusy (reg_wr_data[BIT_FBUSY]),
        .wr_flush (reg_wr_data[BIT_FLUSH]),
        .fbusy    (fbusy),
        .flush    (flush)
    );

    rxdma_fifo_level #(.FIFO_DEPTH(FIFO_DEPTH)) u_level (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (fifo_push),
        .pop      (fifo_pop),
        .flush    (flush),
        .nonempty (nonempty)
    );

    rxdma_pkt_ctl u_pkt (
        .clk      (clk),
        .rst_n    (rst_n),
        .fbusy    (fbusy),
        .sop      (rx_sop),
        .eop      (rx_eop),
        .crc_ok   (eop_crc_ok),
        .irq_ack  (irq_ack),
        .active   (active),
        .busy_sel (ack_busy),
        .irq      (dma_done_irq)
    );

    always_comb begin
        reg_rd_data             = '0;
        reg_rd_data[BIT_NEMPTY] = nonempty;
        reg_rd_data[BIT_RXMON]  = active;
        reg_rd_data[BIT_FBUSY]  = fbusy;
    end

    assign fifo_clr = flush;

    AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd_data[7:4] == 4'h0) && !reg_rd_data[BIT_FLUSH]); // R2

endmodule

// File: tb/tb_rxdma_ctl.sv
module tb_rxdma_ctl;

    localparam int DEPTH = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr_en = 1'b0;
    logic [7:0] reg_wr_data = '0;
    logic [7:0] reg_rd_data;
    logic       fifo_push = 1'b0, fifo_pop = 1'b0, fifo_clr;
    logic       rx_sop = 1'b0, rx_eop = 1'b0, eop_crc_ok = 1'b0;
    logic       ack_busy, irq_ack = 1'b0, dma_done_irq;

    int n_run = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    rxdma_ctl #(.FIFO_DEPTH(DEPTH)) dut (
        .clk, .rst_n, .reg_wr_en, .reg_wr_data, .reg_rd_data,
        .fifo_push, .fifo_pop, .fifo_clr, .rx_sop, .rx_eop, .eop_crc_ok,
        .ack_busy, .irq_ack, .dma_done_irq
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // one clock edge; inputs driven and outputs sampled 1 ns after it
    task automatic tick();
        @(posedge clk);
        #1;
        reg_wr_en = 1'b0; fifo_push = 1'b0; fifo_pop = 1'b0;
        rx_sop = 1'b0; rx_eop = 1'b0; eop_crc_ok = 1'b0; irq_ack = 1'b0;
    endtask

    task automatic wr(input logic [7:0] v);
        reg_wr_en = 1'b1; reg_wr_data = v; tick();
    endtask

    task automatic t_reset();
        check("R1 status", reg_rd_data, 8'h00);
        check("R1 clr", {7'b0, fifo_clr}, 8'h00);
        check("R1 busy", {7'b0, ack_busy}, 8'h00);
        check("R1 irq", {7'b0, dma_done_irq}, 8'h00);
    endtask

    task automatic t_readonly_bits();
        wr(8'hF0);
        check("R2 reserved", reg_rd_data, 8'h00);
        wr(8'h0A);
        check("R3/R6 ro bits ignored", reg_rd_data, 8'h00);
        wr(8'hFF);
        check("R2/R4/R7 write all", reg_rd_data, 8'h01);
        check("R4 clr pulse", {7'b0, fifo_clr}, 8'h01);
        wr(8'h00);
        check("R7 fbusy cleared", reg_rd_data, 8'h00);
    endtask

    task automatic t_level();
        fifo_push = 1'b1; tick();
        check("R3 nonempty", reg_rd_data, 8'h08);
        fifo_pop = 1'b1; tick();
        check("R3 empty again", reg_rd_data, 8'h00);
        fifo_pop = 1'b1; tick();
        fifo_push = 1'b1; tick();
        check("R11 pop when empty ignored", reg_rd_data, 8'h08);
        for (int i = 0; i < DEPTH + 3; i++) begin fifo_push = 1'b1; tick(); end
        for (int i = 0; i < DEPTH - 1; i++) begin fifo_pop = 1'b1; tick(); end
        check("R11 saturate, one left", reg_rd_data, 8'h08);
        fifo_pop = 1'b1; tick();
        check("R11 saturate, drained", reg_rd_data, 8'h00);
    endtask

    task automatic t_flush();
        fifo_push = 1'b1; tick();
        fifo_push = 1'b1; tick();
        wr(8'h04);
        check("R4 pulse high", {7'b0, fifo_clr}, 8'h01);
        check("R4 bit2 reads 0", reg_rd_data, 8'h08);
        fifo_push = 1'b1; tick();
        check("R4 pulse ends", {7'b0, fifo_clr}, 8'h00);
        check("R5 flush beats push", reg_rd_data, 8'h00);
    endtask

    task automatic t_good_packet();
        rx_sop = 1'b1; tick();
        check("R6 monitor on", reg_rd_data, 8'h02);
        check("R7 accepted", {7'b0, ack_busy}, 8'h00);
        wr(8'h02);
        check("R6 write ignored", reg_rd_data, 8'h02);
        rx_eop = 1'b1; eop_crc_ok = 1'b1; tick();
        check("R6 monitor off", reg_rd_data, 8'h00);
        check("R10 irq set", {7'b0, dma_done_irq}, 8'h01);
        tick();
        check("R10 irq sticky", {7'b0, dma_done_irq}, 8'h01);
        irq_ack = 1'b1; tick();
        check("R10 irq cleared", {7'b0, dma_done_irq}, 8'h00);
    endtask

    task automatic t_bad_crc();
        rx_sop = 1'b1; tick();
        rx_eop = 1'b1; tick();
        check("R10 crc error no irq", {7'b0, dma_done_irq}, 8'h00);
    endtask

    task automatic t_refused();
        wr(8'h01);
        rx_sop = 1'b1; tick();
        check("R7 busy ack", {7'b0, ack_busy}, 8'h01);
        check("R7 monitor stays 0", reg_rd_data, 8'h01);
        wr(8'h00);
        check("R8 decision held", {7'b0, ack_busy}, 8'h01);
        rx_eop = 1'b1; eop_crc_ok = 1'b1; tick();
        check("R10 refused no irq", {7'b0, dma_done_irq}, 8'h00);
    endtask

    task automatic t_busy_mid_packet();
        rx_sop = 1'b1; tick();
        wr(8'h01);
        check("R8 still accepted", {7'b0, ack_busy}, 8'h00);
        check("R9 still receiving", reg_rd_data, 8'h03);
        rx_eop = 1'b1; eop_crc_ok = 1'b1; irq_ack = 1'b1; tick();
        check("R9/R10 irq set wins over ack", {7'b0, dma_done_irq}, 8'h01);
        rx_sop = 1'b1; tick();
        check("R9 next packet busy", {7'b0, ack_busy}, 8'h01);
        rx_eop = 1'b1; tick();
        irq_ack = 1'b1; wr(8'h00);
        check("R10 ack clears", {7'b0, dma_done_irq}, 8'h00);
    endtask

    initial begin
        #1;
        t_reset();
        #6 rst_n = 1'b1;
        tick();
        t_reset();
        t_readonly_bits();
        t_level();
        t_flush();
        t_good_packet();
        t_bad_crc();
        t_refused();
        t_busy_mid_packet();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #40000;
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule